// File: doc/BRIEF.md
# Dual-Read Register File with Same-Index Bypass

This block holds the architectural integer registers of a scalar five-stage pipeline. The decode stage reads two source operands through two independent combinational read ports. In the same clock cycle the writeback stage presents at most one result through a single synchronous write port.

Sometimes a decode read names the entry that writeback is updating in that cycle. In that case the read port returns the incoming write data, not the value held in the storage cells. A correct operand therefore never depends on the cells supporting a read and a write of one entry at once.

Entry 0 is an optional hardwired zero: it always reads as zero, it ignores writes and it never takes the bypass. Width, entry count and the zero-entry option are parameters.

Top module: `regbank_2r1w`

## Requirements
- R1: Each read port presents, in the same cycle and without a clock edge, the stored value of the entry its index selects; the two ports are independent of each other.
- R2: When `wr_en` is high at a rising clock edge, entry `wr_idx` holds `wr_data` from that edge on, and reads from the following cycle return it.
- R3: When `wr_en` is low, no entry changes, and a read whose index equals `wr_idx` returns the stored value, not `wr_data`.
- R4: When `wr_en` is high and a read index equals `wr_idx` (other than entry 0), that read port outputs `wr_data` in the same cycle, before the edge that stores it.
- R5: Entry 0 always reads as zero on both ports; a write to index 0 is discarded and is never bypassed.
- R6: An active-low `rst_n` clears every entry to zero.
- R7: A write changes only the addressed entry; every other entry keeps its value.
- R8: Both ports given the same index return the same value, including in a bypass cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| rd_a_idx | input | 5 | Index for read port A |
| rd_a_data | output | 32 | Operand A, combinational |
| rd_b_idx | input | 5 | Index for read port B |
| rd_b_data | output | 32 | Operand B, combinational |
| wr_en | input | 1 | Write request from writeback |
| wr_idx | input | 5 | Entry to write |
| wr_data | input | 32 | Value to write, also the bypass source |

## Verification
The bench builds the block with its defaults: 32 entries of 32 bits, with the zero entry enabled. With these values the random index stream reaches every entry, including entry 0 and the top entry 31. It also makes read and write indices collide often enough to exercise the bypass on each port and on both ports at once. Directed cycles then cover the cases that random traffic hits only rarely: a write to entry 0 while it is being read, and a disabled write whose index matches a read.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int unsigned RB_DEF_DATA_W   = 32;
   localparam int unsigned RB_DEF_NUM_REGS = 32;

   function automatic int unsigned rb_idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/regbank_store.sv
module regbank_store
   import regbank_pkg::*;
#(
   parameter int unsigned DATA_W   = RB_DEF_DATA_W,
   parameter int unsigned NUM_REGS = RB_DEF_NUM_REGS,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = rb_idx_bits(NUM_REGS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]   cells
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
      if (ZERO_REG && g == 0) begin : g_zero
         assign cells[g] = '0;
      end else begin : g_flop
         logic hit;
         assign hit = wr_en && (wr_idx == IDX_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cells[g] <= '0;
            else if (hit) cells[g] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/regbank_rdport.sv
module regbank_rdport
   import regbank_pkg::*;
#(
   parameter int unsigned DATA_W   = RB_DEF_DATA_W,
   parameter int unsigned NUM_REGS = RB_DEF_NUM_REGS,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = rb_idx_bits(NUM_REGS)
) (
   input  logic [IDX_W-1:0]                  rd_idx,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]   cells,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [DATA_W-1:0]                 rd_data
);
   logic idx_ok;
   logic fwd;
   logic [DATA_W-1:0] stored;

   if (ZERO_REG) begin : g_zfilt
      assign idx_ok = (rd_idx != '0);
   end else begin : g_nofilt
      assign idx_ok = 1'b1;
   end

   assign fwd = wr_en && (wr_idx == rd_idx) && idx_ok;

   always_comb begin
      stored = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDX_W'(i)) stored = cells[i];
      end
   end

   assign rd_data = fwd ? wr_data : stored;
endmodule

// File: rtl/regbank_2r1w.sv
module regbank_2r1w
   import regbank_pkg::*;
#(
   parameter int unsigned DATA_W   = RB_DEF_DATA_W,
   parameter int unsigned NUM_REGS = RB_DEF_NUM_REGS,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = rb_idx_bits(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("regbank_2r1w: DATA_W must be at least 1");
   end
   if (NUM_REGS < 2) begin : g_bad_depth
      $error("regbank_2r1w: NUM_REGS must be at least 2");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_pow2
      $error("regbank_2r1w: NUM_REGS must be a power of two");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] cells;
   logic [1:0][IDX_W-1:0]           ridx;
   logic [1:0][DATA_W-1:0]          rdat;

   assign ridx[0]   = rd_a_idx;
   assign ridx[1]   = rd_b_idx;
   assign rd_a_data = rdat[0];
   assign rd_b_data = rdat[1];

   regbank_store #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ZERO_REG(ZERO_REG)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .cells(cells)
   );

   for (genvar p = 0; p < 2; p++) begin : g_port
      regbank_rdport #(
         .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ZERO_REG(ZERO_REG)
      ) u_rd (
         .rd_idx(ridx[p]), .cells(cells), .wr_en(wr_en), .wr_idx(wr_idx),
         .wr_data(wr_data), .rd_data(rdat[p])
      );
   end
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
   import regbank_pkg::*;
#(
   parameter int unsigned DATA_W   = RB_DEF_DATA_W,
   parameter int unsigned NUM_REGS = RB_DEF_NUM_REGS,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned IDX_W   = rb_idx_bits(NUM_REGS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IDX_W-1:0]  rd_a_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [IDX_W-1:0]  rd_b_idx,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data
);
   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   logic a_coll, b_coll, wr_real;
   assign a_coll  = wr_en && (wr_idx == rd_a_idx);
   assign b_coll  = wr_en && (wr_idx == rd_b_idx);
   assign wr_real = !ZERO_REG || (wr_idx != '0);

   assert_zero_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG && rd_a_idx == '0) |-> rd_a_data == '0);

   assert_zero_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG && rd_b_idx == '0) |-> rd_b_data == '0);

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(a_coll && wr_real) && $stable(rd_a_idx) && !a_coll)
      |-> rd_a_data == $past(wr_data));

   assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(!a_coll) && $stable(rd_a_idx) && !a_coll)
      |-> $stable(rd_a_data));

   assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(!b_coll) && $stable(rd_b_idx) && !b_coll)
      |-> $stable(rd_b_data));

   assert_same_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == rd_b_idx) |-> rd_a_data == rd_b_data);
endmodule

bind regbank_2r1w regbank_chk #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ZERO_REG(ZERO_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
   .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en),
   .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/sim_regbank_2r1w.sv
`timescale 1ns/1ps
module sim_regbank_2r1w;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0;

   int total = 0;
   int bad   = 0;
   logic [31:0] mdl [32];
   bit done = 0;

   always #10 clk = ~clk;

   regbank_2r1w u0 (
      .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_data(wr_data)
   );

   function automatic logic [31:0] exp_rd(input logic [4:0] idx, input logic we,
                                          input logic [4:0] wi, input logic [31:0] wd);
      if (idx == 5'd0) return 32'd0;
      if (we && wi == idx) return wd;
      return mdl[idx];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input string req, input logic [4:0] ai, input logic [4:0] bi,
                      input logic we, input logic [4:0] wi, input logic [31:0] wd);
      rd_a_idx = ai; rd_b_idx = bi; wr_en = we; wr_idx = wi; wr_data = wd;
      #2;
      chk({req, " port A"}, rd_a_data, exp_rd(ai, we, wi, wd));
      chk({req, " port B"}, rd_b_data, exp_rd(bi, we, wi, wd));
      @(posedge clk);
      if (we && wi != 5'd0) mdl[wi] = wd;
      #1;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R6: every entry zero after reset, seen on both ports
      for (int i = 0; i < 32; i++) cyc("R6", 5'(i), 5'(31 - i), 1'b0, 5'd0, 32'd0);

      // R2: write then read next cycle
      cyc("R2", 5'd1, 5'd2, 1'b1, 5'd5, 32'hDEAD_BEEF);
      cyc("R2", 5'd5, 5'd0, 1'b0, 5'd0, 32'd0);
      // R4: same-cycle bypass on A only, then on both with R8
      cyc("R4", 5'd7, 5'd5, 1'b1, 5'd7, 32'h1234_5678);
      cyc("R4 R8", 5'd7, 5'd7, 1'b1, 5'd7, 32'hCAFE_0001);
      cyc("R2", 5'd7, 5'd7, 1'b0, 5'd7, 32'h0BAD_0BAD);
      // R3: disabled write with matching index neither bypasses nor stores
      cyc("R3", 5'd9, 5'd9, 1'b1, 5'd9, 32'hAAAA_5555);
      cyc("R3", 5'd9, 5'd1, 1'b0, 5'd9, 32'h5555_AAAA);
      cyc("R3", 5'd9, 5'd9, 1'b0, 5'd0, 32'd0);
      // R5: write to entry 0 while reading it: no bypass, no store
      cyc("R5", 5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF);
      cyc("R5", 5'd0, 5'd0, 1'b0, 5'd0, 32'd0);
      // R7: top entry write leaves neighbours untouched
      cyc("R7", 5'd30, 5'd0, 1'b1, 5'd31, 32'h8000_0001);
      cyc("R7", 5'd31, 5'd30, 1'b0, 5'd0, 32'd0);

      // R1 R7 R4: random traffic with frequent index collisions
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] ai, bi, wi;
         logic we;
         wi = 5'($urandom_range(0, 31));
         ai = ($urandom_range(0, 3) == 0) ? wi : 5'($urandom_range(0, 31));
         bi = ($urandom_range(0, 3) == 0) ? ai : 5'($urandom_range(0, 31));
         we = ($urandom_range(0, 3) != 0);
         cyc("R1 R7 R4", ai, bi, we, wi, $urandom());
      end

      // R6: reset mid-run clears written entries
      rst_n = 1'b0; #2; rst_n = 1'b1;
      for (int i = 0; i < 32; i++) mdl[i] = '0;
      for (int i = 0; i < 32; i++) cyc("R6", 5'(i), 5'(i), 1'b0, 5'd0, 32'd0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule